// File: doc/BRIEF.md
# Block Transfer and Compare Sequencer

This block is a small sequential engine that walks a byte region of memory one element at a time. It holds a 16-bit source pointer, a 16-bit destination pointer, a 16-bit element count, an 8-bit accumulator value and an 8-bit flag byte. A one-cycle `start` pulse loads all of these from the input ports and selects one of eight modes with `mode`. Bit 0 of `mode` sets the direction (0 means up, 1 means down). Bit 1 chooses the operation (0 means copy, 1 means compare). Bit 2 chooses between a single step (0) and a repeating block (1).

Each element follows a fixed micro-sequence. The sequencer first issues a read at the source pointer. It captures the returned byte one cycle later. In the next cycle it either writes that byte to the destination pointer (copy) or compares it against the accumulator (compare). In that same cycle it updates the pointers, the count and the flags. It then pads with idle cycles until the element has used its full cycle budget. A repeating operation re-enters the same sequence until its stop condition holds. A one-cycle `done` pulse marks the end, and the pointer, count and flag outputs then hold the results.

States: `ST_IDLE` (waiting), `ST_FETCH` (read issued), `ST_CAPT` (read data captured), `ST_STORE` (write/compare and register update), `ST_PAD` (idle fill). Transitions: IDLE→FETCH on `start`; FETCH→CAPT, CAPT→STORE and STORE→PAD unconditionally; PAD→FETCH at cycle 20 of an element that loops again; PAD→IDLE at cycle 15 of a final element, with `done` high in that cycle.

Top module: `blkxfer_seq`

## Requirements
- R1: A copy step (mode bit 1 = 0) reads the byte at the source pointer and writes it at the destination pointer. It then moves both pointers by one, up when mode bit 0 = 0 and down when it is 1, and decrements the count by one.
- R2: A compare step (mode bit 1 = 1) forms accumulator minus the byte at the source pointer. Flag bit 7 (sign) is the result's top bit. Flag bit 6 (zero) is set when the result is zero. Flag bit 4 (half) is set when the low nibble borrows. Flag bit 1 (subtract) is set to 1. The step moves only the source pointer, decrements the count, and leaves the destination pointer unchanged.
- R3: A repeating copy (mode bit 2 = 1) keeps stepping until the decremented count is zero.
- R4: A repeating compare stops after the element where the byte equals the accumulator, or after the element where the count reaches zero, whichever comes first.
- R5: A single step, and the final element of a repeating block, takes 16 cycles. Every element that loops again takes 21 cycles. `done` rises exactly 16 + 21·(n−1) cycles after the `start` cycle for n elements, and it lasts one cycle.
- R6: After a copy step, flag bit 4 and flag bit 1 are 0, flag bit 2 (parity/overflow) shows whether the new count is non-zero, and bits 7, 6, 5, 3 and 0 keep their loaded values. A completed repeating copy therefore ends with bit 2 = 0.
- R7: A compare step sets flag bit 2 when the new count is non-zero, and leaves flag bits 0, 5 and 3 unchanged.
- R8: A starting count of zero wraps to 0xFFFF on the first decrement, so it is treated as 65536 elements. A single step from zero gives count 0xFFFF and flag bit 2 = 1.
- R9: The memory port uses a read latency of one cycle. Each element issues exactly one read. A write is issued once per copy element and never for a compare.
- R10: Synchronous active-high reset returns the block to idle with `busy`, `done`, `mem_re` and `mem_we` low. A `start` pulse while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin, accepted only when idle |
| mode | input | 3 | bit0 direction, bit1 compare, bit2 repeat |
| hl_in | input | 16 | Initial source pointer |
| de_in | input | 16 | Initial destination pointer |
| bc_in | input | 16 | Initial element count |
| acc_in | input | 8 | Accumulator value for compares |
| flags_in | input | 8 | Initial flag byte |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Read request, data returns next cycle |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |
| hl_out | output | 16 | Current source pointer |
| de_out | output | 16 | Current destination pointer |
| bc_out | output | 16 | Current count |
| flags_out | output | 8 | Current flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase or a wrong cycle counter moves `done` away from its 16/21-cycle slot, so the measured latency differs from the first element onward. A corrupted pointer or count shows up in the next `mem_addr` of the following element, and at `done` in the register outputs and the copied memory image. A wrong loop decision changes the element count at once: this appears as an early or late `done`, a wrong final count, and extra or missing reads and writes on the memory port.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CAPT,
        ST_STORE,
        ST_PAD
    } seq_state_t;

    // mode bit positions
    localparam int MB_DIR = 0;
    localparam int MB_CMP = 1;
    localparam int MB_REP = 2;

    // flag byte bit positions
    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_H  = 4;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;
endpackage

// File: rtl/blkxfer_ptr.sv
module blkxfer_ptr #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] hl,
    input  logic [AW-1:0] de,
    input  logic [AW-1:0] bc,
    input  logic          dir_down,
    output logic [AW-1:0] hl_nx,
    output logic [AW-1:0] de_nx,
    output logic [AW-1:0] bc_nx,
    output logic          bc_nz
);
    logic [AW-1:0] step;

    always_comb begin
        step  = dir_down ? {AW{1'b1}} : AW'(1);
        hl_nx = hl + step;
        de_nx = de + step;
        bc_nx = bc - AW'(1);
        bc_nz = |bc_nx;
    end
endmodule

// File: rtl/blkxfer_cmp.sv
module blkxfer_cmp
    import blkxfer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] mbyte,
    input  logic          is_cmp,
    input  logic          bc_nz,
    input  logic [7:0]    flg_old,
    output logic [7:0]    flg_new,
    output logic          match
);
    localparam int NIB = (DW >= 8) ? 4 : DW / 2;

    logic [DW-1:0] diff;
    logic          half_borrow;

    always_comb begin
        diff        = acc - mbyte;
        half_borrow = acc[NIB-1:0] < mbyte[NIB-1:0];
        match       = (diff == '0);
        flg_new     = flg_old;
        flg_new[FB_PV] = bc_nz;
        if (is_cmp) begin
            flg_new[FB_S] = diff[DW-1];
            flg_new[FB_Z] = match;
            flg_new[FB_H] = half_borrow;
            flg_new[FB_N] = 1'b1;
        end else begin
            flg_new[FB_H] = 1'b0;
            flg_new[FB_N] = 1'b0;
        end
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int SINGLE_CYC = 16,
    parameter int LOOP_CYC   = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] hl_in,
    input  logic [AW-1:0] de_in,
    input  logic [AW-1:0] bc_in,
    input  logic [DW-1:0] acc_in,
    input  logic [7:0]    flags_in,
    output logic [AW-1:0] mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] hl_out,
    output logic [AW-1:0] de_out,
    output logic [AW-1:0] bc_out,
    output logic [7:0]    flags_out,
    output logic          busy,
    output logic          done
);
    localparam int CNT_W = $clog2(LOOP_CYC);
    localparam logic [CNT_W-1:0] LAST_SINGLE = CNT_W'(SINGLE_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_LOOP   = CNT_W'(LOOP_CYC - 1);

    seq_state_t    state, nxt;
    logic [CNT_W-1:0] cnt;
    logic [2:0]    mode_q;
    logic [AW-1:0] hl_q, de_q, bc_q;
    logic [DW-1:0] acc_q, data_q;
    logic [7:0]    flg_q;
    logic          again_q;

    logic [AW-1:0] hl_nx, de_nx, bc_nx;
    logic          bc_nz, match;
    logic [7:0]    flg_nx;
    logic [CNT_W-1:0] cnt_end;
    logic          pad_end;

    blkxfer_ptr #(.AW(AW)) ptr_i (
        .hl       (hl_q),
        .de       (de_q),
        .bc       (bc_q),
        .dir_down (mode_q[MB_DIR]),
        .hl_nx    (hl_nx),
        .de_nx    (de_nx),
        .bc_nx    (bc_nx),
        .bc_nz    (bc_nz)
    );

    blkxfer_cmp #(.DW(DW)) cmp_i (
        .acc     (acc_q),
        .mbyte   (data_q),
        .is_cmp  (mode_q[MB_CMP]),
        .bc_nz   (bc_nz),
        .flg_old (flg_q),
        .flg_new (flg_nx),
        .match   (match)
    );

    assign cnt_end = again_q ? LAST_LOOP : LAST_SINGLE;
    assign pad_end = (state == ST_PAD) && (cnt == cnt_end);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_FETCH;
            ST_FETCH: nxt = ST_CAPT;
            ST_CAPT:  nxt = ST_STORE;
            ST_STORE: nxt = ST_PAD;
            ST_PAD:   if (pad_end) nxt = again_q ? ST_FETCH : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register and element cycle counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE || pad_end) cnt <= '0;
            else                             cnt <= cnt + CNT_W'(1);
        end
    end

    // operand registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            hl_q    <= '0;
            de_q    <= '0;
            bc_q    <= '0;
            acc_q   <= '0;
            flg_q   <= '0;
            data_q  <= '0;
            again_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q  <= mode;
                        hl_q    <= hl_in;
                        de_q    <= de_in;
                        bc_q    <= bc_in;
                        acc_q   <= acc_in;
                        flg_q   <= flags_in;
                        again_q <= 1'b0;
                    end
                end
                ST_CAPT: data_q <= mem_rdata;
                ST_STORE: begin
                    hl_q  <= hl_nx;
                    bc_q  <= bc_nx;
                    flg_q <= flg_nx;
                    if (!mode_q[MB_CMP]) de_q <= de_nx;
                    again_q <= mode_q[MB_REP] && bc_nz && !(mode_q[MB_CMP] && match);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_re    = (state == ST_FETCH);
        mem_we    = (state == ST_STORE) && !mode_q[MB_CMP];
        mem_addr  = (state == ST_STORE) ? de_q : hl_q;
        mem_wdata = data_q;
        busy      = (state != ST_IDLE);
        done      = pad_end && !again_q;
        hl_out    = hl_q;
        de_out    = de_q;
        bc_out    = bc_q;
        flags_out = flg_q;
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt <= LAST_LOOP));

    // R9
    write_copy_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !mode_q[MB_CMP]);

    // R9
    read_write_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    // R8
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE) |=> (bc_q == $past(bc_q) - AW'(1)));

    // R2
    dest_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE && mode_q[MB_CMP]) |=> $stable(de_q));

    // R7
    carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STORE) |=> (flg_q[FB_C] == $past(flg_q[FB_C])));

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && state != ST_PAD) |=> busy);
endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [2:0]  mode;
    logic [15:0] hl_in, de_in, bc_in;
    logic [7:0]  acc_in, flags_in;
    logic [15:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [15:0] hl_out, de_out, bc_out;
    logic [7:0]  flags_out;
    logic        busy, done;

    int total = 0;
    int bad   = 0;
    int re_cnt = 0;
    int we_cnt = 0;

    logic [7:0] mem   [4096];
    logic [7:0] refm  [4096];

    always #5 clk = ~clk;

    blkxfer_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in),
        .acc_in(acc_in), .flags_in(flags_in),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out),
        .flags_out(flags_out), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (mem_re) begin
            mem_rdata <= mem[mem_addr[11:0]];
            re_cnt <= re_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // launch one operation, compare against the bench model
    task automatic run_op(input logic [2:0] m, input logic [15:0] h, input logic [15:0] d,
                          input logic [15:0] b, input logic [7:0] a, input logic [7:0] f,
                          input string req, input bit poke_mid);
        logic [15:0] eh, ed, eb;
        logic [7:0]  ef, mb, df;
        int n, cyc;
        bit go, mism;
        eh = h; ed = d; eb = b; ef = f; n = 0; go = 1'b1;
        while (go) begin
            n++;
            mb = refm[eh[11:0]];
            if (!m[1]) begin
                refm[ed[11:0]] = mb;
                ed = m[0] ? ed - 16'd1 : ed + 16'd1;
            end
            eh = m[0] ? eh - 16'd1 : eh + 16'd1;
            eb = eb - 16'd1;
            ef[2] = (eb != 16'd0);
            if (m[1]) begin
                df = a - mb;
                ef[7] = df[7];
                ef[6] = (df == 8'd0);
                ef[4] = (a[3:0] < mb[3:0]);
                ef[1] = 1'b1;
            end else begin
                ef[4] = 1'b0;
                ef[1] = 1'b0;
            end
            go = m[2] && (eb != 16'd0) && !(m[1] && a == mb);
        end
        @(negedge clk);
        re_cnt = 0; we_cnt = 0;
        mode = m; hl_in = h; de_in = d; bc_in = b; acc_in = a; flags_in = f;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 20000) begin
            if (poke_mid && cyc == 10) begin
                start = 1'b1; mode = ~m; hl_in = 16'h0F00; bc_in = 16'd9;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(req, "done latency (R5)", cyc, 16 + 21 * (n - 1));
        chk(req, "source pointer", hl_out, eh);
        chk(req, "dest pointer", de_out, ed);
        chk(req, "count", bc_out, eb);
        chk(req, "flags", flags_out, ef);
        chk(req, "reads per element (R9)", re_cnt, n);
        chk(req, "writes (R9)", we_cnt, m[1] ? 0 : n);
        mism = 1'b0;
        for (int i = 0; i < 4096; i++) if (mem[i] !== refm[i]) mism = 1'b1;
        chk(req, "memory image", mism, 0);
        @(negedge clk);
        chk(req, "done one cycle (R5)", done, 0);
        chk(req, "idle after done", busy, 0);
    endtask

    task automatic t_reset();
        chk("R10", "busy after reset", busy, 0);
        chk("R10", "done after reset", done, 0);
        chk("R10", "mem_we after reset", mem_we, 0);
        chk("R10", "mem_re after reset", mem_re, 0);
    endtask

    task automatic t_copy_single();
        run_op(3'b000, 16'h0010, 16'h0200, 16'd7, 8'h00, 8'hE9, "R1 R6 up", 1'b0);
        run_op(3'b001, 16'h0030, 16'h0300, 16'd1, 8'h00, 8'h17, "R1 R6 down", 1'b0);
    endtask

    task automatic t_copy_repeat();
        run_op(3'b100, 16'h0040, 16'h0400, 16'd5, 8'h00, 8'h04, "R3 up", 1'b0);
        run_op(3'b101, 16'h0060, 16'h0500, 16'd3, 8'h00, 8'h00, "R3 down", 1'b0);
    endtask

    task automatic t_cmp_single();
        // low nibble borrow and carry bit set beforehand
        run_op(3'b010, 16'h0001, 16'h0700, 16'd4, 8'h00, 8'h29, "R2 R7", 1'b0);
        run_op(3'b011, 16'h0002, 16'h0700, 16'd1, mem[2], 8'h00, "R2 R7 equal", 1'b0);
    endtask

    task automatic t_cmp_repeat();
        run_op(3'b110, 16'h0080, 16'h0000, 16'd10, mem[16'h0082], 8'h01, "R4 match", 1'b0);
        run_op(3'b111, 16'h00A0, 16'h0000, 16'd4, 8'hFF, 8'h00, "R4 exhaust", 1'b0);
    endtask

    task automatic t_wrap();
        run_op(3'b000, 16'h0100, 16'h0600, 16'd0, 8'h00, 8'h00, "R8", 1'b0);
    endtask

    task automatic t_busy_start();
        run_op(3'b100, 16'h00C0, 16'h0800, 16'd3, 8'h00, 8'h00, "R10 busy start", 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'(i * 7 + 3);
            refm[i] = 8'(i * 7 + 3);
        end
        mem[2]  = 8'h55; refm[2]  = 8'h55;
        mem[1]  = 8'h0F; refm[1]  = 8'h0F;
        rst = 1'b1; start = 1'b0; mode = '0;
        hl_in = '0; de_in = '0; bc_in = '0; acc_in = '0; flags_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_copy_single();
        t_copy_repeat();
        t_cmp_single();
        t_cmp_repeat();
        t_wrap();
        t_busy_start();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule